// File: doc/BRIEF.md
# Quad DAC SPI Register Interface

This block is the serial register interface of a four-channel, 16-bit digital-to-analog converter. A host reaches it over a four-wire SPI link made of a serial clock, a data input, an active-low chip select and a data output. Every transfer is one 24-bit frame. The first byte is a command that holds a read flag and a register address. The remaining 16 bits carry data. The block decodes each complete frame into a small register map: a fixed identifier, serial-port settings, general settings, broadcast settings, power-down flags, output ranges, a trigger register and one data register per channel.

Each channel has two registers. A buffer register takes the host's data write. An active register drives the channel's output code. A channel in immediate mode copies the written value into its active register when chip select rises at the end of the frame. A channel in deferred mode holds the new value in its buffer until a trigger arrives, either a falling edge on the load pin or a write to the trigger register. The trigger loads every buffer into its active register in the same cycle, so several outputs can change together.

All pins are brought into the system clock through synchronisers and decoded from their edges. For this reason the serial clock must run well below the system clock. The four active codes leave the block on a flat output bus, channel A in the low bits. The analog path, range scaling, CRC and alarms are handled outside this block.

Top module: `quad_dac_spi_regs`

## Requirements
- R1: A frame is 24 bits, most significant bit first. Bit 23 is the read flag (1 = read). Bits 22:16 are the register address. Bits 15:0 are the data. Address 0x10+n is the data register of channel n, for n = 0..3 (A..D).
- R2: A frame counts only if chip select rises after exactly 24 falling serial-clock edges. If chip select rises earlier, the frame changes no register and no output.
- R3: Input data is taken on each falling edge of the serial clock, so frames work with the clock idling low (mode 1) and with the clock idling high (mode 2).
- R4: Bit 1 of the serial-port register (address 0x03) selects when the output bit advances. With 0, it advances on the rising edge that follows a falling edge. With 1, it advances on the falling edge itself, half a clock earlier.
- R5: The frame after a read returns 0x00 followed by the addressed register's 16-bit value. The frame after any other complete frame returns all zeros. The output pin is 0 while chip select is high.
- R6: After reset, address 0x01 reads 0x0A84, address 0x03 reads 0x0AA4, the general register (0x04) reads 0, all data registers read 0 and all output codes are 0.
- R7: The identifier at 0x01 cannot be written. Writes to unmapped addresses have no effect, and unmapped addresses read as zero.
- R8: A channel whose bit n in the general register (0x04) is 0 is in immediate mode. Its output takes the written code at the end of the data-write frame.
- R9: A channel whose bit n in the general register is 1 is in deferred mode. A data write changes only its buffer. A falling edge on the load pin copies every buffer into its active register at once.
- R10: Writing 1 to bit 0 of the trigger register (0x0E) causes the same load as the load pin. The register always reads back 0.
- R11: While bit 5 of the serial-port register is 1 (device power-down), every output code is 0. The active values are kept and come back when the bit is cleared.
- R12: A read of a channel data register returns that channel's buffer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| sdin_i | input | 1 | Serial data from the host |
| ldac_ni | input | 1 | Load pin, active on its falling edge |
| sdo_o | output | 1 | Serial data to the host |
| dac_code_o | output | 64 | Active codes of channels A..D, 16 bits each, channel A lowest |

## Verification
The bench builds the block with its default parameters: 16-bit codes, four channels and two synchroniser stages. With four channels, the data addresses 0x10 to 0x13 and a mix of immediate and deferred channels can all be driven through real frames. The 24-bit frame keeps every read-back word and every bit-timing check exact. Each serial-clock phase lasts six to ten system cycles, which is longer than the synchroniser and edge-detect path. This lets the bench tell the two output-advance settings apart by sampling between a falling and a rising edge, in both clock polarities.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] ADDR_ID     = 7'h01;
  localparam logic [ADDR_W-1:0] ADDR_SPICFG = 7'h03;
  localparam logic [ADDR_W-1:0] ADDR_GENCFG = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_BRDCFG = 7'h05;
  localparam logic [ADDR_W-1:0] ADDR_PWDN   = 7'h09;
  localparam logic [ADDR_W-1:0] ADDR_RANGE  = 7'h0A;
  localparam logic [ADDR_W-1:0] ADDR_TRIG   = 7'h0E;
  localparam logic [ADDR_W-1:0] ADDR_DAC0   = 7'h10;

  localparam logic [15:0] DEVICE_ID  = 16'h0A84;
  localparam logic [15:0] SPICFG_RST = 16'h0AA4;

  localparam int FSDO_BIT      = 1;
  localparam int DEVPD_BIT     = 5;
  localparam int SOFT_LDAC_BIT = 0;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qdac_spi_rx.sv
module qdac_spi_rx #(
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_s_i,
  input  logic            cs_n_s_i,
  input  logic            sdin_s_i,
  input  logic            fsdo_i,
  input  logic [8+DW-1:0] tx_word_i,
  output logic            frame_valid_o,
  output logic [8+DW-1:0] frame_o,
  output logic            sdo_o
);
  localparam int F  = 8 + DW;
  localparam int CW = $clog2(F + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(F);
  localparam logic [CW-1:0] CNT_OVER = CW'(F + 1);

  logic          sclk_q, cs_n_q;
  logic          sclk_fall, sclk_rise, cs_fall, cs_rise;
  logic [CW-1:0] cnt_q;
  logic [F-1:0]  rx_sh_q, tx_sh_q;
  logic          launch_pend_q;

  assign sclk_fall = sclk_q & ~sclk_s_i;
  assign sclk_rise = ~sclk_q & sclk_s_i;
  assign cs_fall   = cs_n_q & ~cs_n_s_i;
  assign cs_rise   = ~cs_n_q & cs_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q        <= 1'b0;
      cs_n_q        <= 1'b1;
      cnt_q         <= '0;
      rx_sh_q       <= '0;
      tx_sh_q       <= '0;
      launch_pend_q <= 1'b0;
      frame_valid_o <= 1'b0;
    end else begin
      sclk_q        <= sclk_s_i;
      cs_n_q        <= cs_n_s_i;
      frame_valid_o <= cs_rise && (cnt_q == CNT_FULL);
      if (cs_fall) begin
        cnt_q         <= '0;
        tx_sh_q       <= tx_word_i;
        launch_pend_q <= 1'b0;
      end else if (!cs_n_s_i) begin
        if (sclk_fall) begin
          rx_sh_q <= {rx_sh_q[F-2:0], sdin_s_i};
          if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
          if (fsdo_i) tx_sh_q <= {tx_sh_q[F-2:0], 1'b0};
          else        launch_pend_q <= 1'b1;
        end else if (sclk_rise && launch_pend_q && !fsdo_i) begin
          tx_sh_q       <= {tx_sh_q[F-2:0], 1'b0};
          launch_pend_q <= 1'b0;
        end
      end
    end
  end

  assign frame_o = rx_sh_q;
  assign sdo_o   = ~cs_n_q & tx_sh_q[F-1];

  p_cnt_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OVER);

  p_rx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall |=> $stable(rx_sh_q));

  p_valid_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> (cs_n_q && $past(cnt_q) == CNT_FULL));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NCH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_valid_i,
  input  logic [8+DW-1:0]   frame_i,
  input  logic [NCH*DW-1:0] buf_i,
  output logic              fsdo_o,
  output logic              dev_pd_o,
  output logic              soft_trig_o,
  output logic [NCH-1:0]    sync_mode_o,
  output logic [NCH-1:0]    wr_ch_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [8+DW-1:0]   tx_word_o
);
  logic              is_rd, wr_frame;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     data, rd_val;
  logic [DW-1:0]     spicfg_q, gencfg_q, brdcfg_q, pwdn_q, range_q;

  assign is_rd     = frame_i[8+DW-1];
  assign addr      = frame_i[8+DW-2:DW];
  assign data      = frame_i[DW-1:0];
  assign wr_frame  = frame_valid_i & ~is_rd;
  assign wr_data_o = data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spicfg_q    <= DW'(SPICFG_RST);
      gencfg_q    <= '0;
      brdcfg_q    <= '0;
      pwdn_q      <= '0;
      range_q     <= '0;
      soft_trig_o <= 1'b0;
      tx_word_o   <= '0;
    end else begin
      soft_trig_o <= wr_frame && (addr == ADDR_TRIG) && data[SOFT_LDAC_BIT];
      if (frame_valid_i) tx_word_o <= is_rd ? {CMD_W'(0), rd_val} : '0;
      if (wr_frame) begin
        case (addr)
          ADDR_SPICFG: spicfg_q <= data;
          ADDR_GENCFG: gencfg_q <= data;
          ADDR_BRDCFG: brdcfg_q <= data;
          ADDR_PWDN:   pwdn_q   <= data;
          ADDR_RANGE:  range_q  <= data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      ADDR_ID:     rd_val = DW'(DEVICE_ID);
      ADDR_SPICFG: rd_val = spicfg_q;
      ADDR_GENCFG: rd_val = gencfg_q;
      ADDR_BRDCFG: rd_val = brdcfg_q;
      ADDR_PWDN:   rd_val = pwdn_q;
      ADDR_RANGE:  rd_val = range_q;
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(ADDR_DAC0 + c)) rd_val = buf_i[c*DW +: DW];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_wr
    assign wr_ch_o[c] = wr_frame && (addr == ADDR_W'(ADDR_DAC0 + c));
  end

  assign sync_mode_o = gencfg_q[NCH-1:0];
  assign fsdo_o      = spicfg_q[FSDO_BIT];
  assign dev_pd_o    = spicfg_q[DEVPD_BIT];

  p_soft_self_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_trig_o |=> !soft_trig_o);
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          sync_mode_i,
  input  logic          trig_i,
  output logic [DW-1:0] buf_o,
  output logic [DW-1:0] active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o    <= '0;
      active_o <= '0;
    end else begin
      if (wr_i) buf_o <= data_i;
      if (wr_i && !sync_mode_i) active_o <= data_i;
      else if (trig_i)          active_o <= buf_o;
    end
  end

  p_buf_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> buf_o == $past(data_i));

  p_async_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sync_mode_i) |=> active_o == $past(data_i));

  p_sync_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && !trig_i) |=> $stable(active_o));
endmodule

// File: rtl/quad_dac_spi_regs.sv
module quad_dac_spi_regs
  import qdac_pkg::*;
#(
  parameter int DW          = 16,
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdin_i,
  input  logic              ldac_ni,
  output logic              sdo_o,
  output logic [NCH*DW-1:0] dac_code_o
);
  localparam int F = CMD_W + DW;

  logic [3:0]        pins_s;
  logic              sclk_s, cs_n_s, sdin_s, ldac_n_s, ldac_n_q;
  logic              frame_valid, fsdo, dev_pd, soft_trig, trig;
  logic [F-1:0]      frame, tx_word;
  logic [NCH-1:0]    sync_mode, wr_ch;
  logic [DW-1:0]     wr_data;
  logic [NCH*DW-1:0] buf_all, act_all;

  qdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ldac_ni, sdin_i, cs_ni, sclk_i}),
    .q_o   (pins_s)
  );
  assign {ldac_n_s, sdin_s, cs_n_s, sclk_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ldac_n_q <= 1'b1;
    else         ldac_n_q <= ldac_n_s;
  end
  assign trig = (ldac_n_q & ~ldac_n_s) | soft_trig;

  qdac_spi_rx #(.DW(DW)) i_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_s_i     (sclk_s),
    .cs_n_s_i     (cs_n_s),
    .sdin_s_i     (sdin_s),
    .fsdo_i       (fsdo),
    .tx_word_i    (tx_word),
    .frame_valid_o(frame_valid),
    .frame_o      (frame),
    .sdo_o        (sdo_o)
  );

  qdac_regs #(.DW(DW), .NCH(NCH)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_valid_i(frame_valid),
    .frame_i      (frame),
    .buf_i        (buf_all),
    .fsdo_o       (fsdo),
    .dev_pd_o     (dev_pd),
    .soft_trig_o  (soft_trig),
    .sync_mode_o  (sync_mode),
    .wr_ch_o      (wr_ch),
    .wr_data_o    (wr_data),
    .tx_word_o    (tx_word)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qdac_channel #(.DW(DW)) i_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_ch[c]),
      .data_i     (wr_data),
      .sync_mode_i(sync_mode[c]),
      .trig_i     (trig),
      .buf_o      (buf_all[c*DW +: DW]),
      .active_o   (act_all[c*DW +: DW])
    );
    assign dac_code_o[c*DW +: DW] = dev_pd ? '0 : act_all[c*DW +: DW];
  end
endmodule

// File: tb/test_quad_dac_spi_regs.sv
module test_quad_dac_spi_regs;
  localparam int DW  = 16;
  localparam int NCH = 4;
  localparam int Q   = 6;
  localparam int H   = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdin = 1'b0, ldac_n = 1'b1;
  logic sdo;
  logic [NCH*DW-1:0] dac;

  always #10 clk = ~clk;

  quad_dac_spi_regs i_quad_dac_spi_regs (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sclk_i    (sclk),
    .cs_ni     (cs_n),
    .sdin_i    (sdin),
    .ldac_ni   (ldac_n),
    .sdo_o     (sdo),
    .dac_code_o(dac)
  );

  int n_cmp = 0, n_bad = 0;
  bit settle = 1'b1, mode2 = 1'b0, done = 1'b0;
  logic [15:0] m_spi = 16'h0AA4, m_gen = '0, m_brd = '0, m_pwd = '0, m_rng = '0;
  logic [15:0] m_buf [NCH];
  logic [15:0] m_act [NCH];
  logic [23:0] m_pend = '0, last_rx = '0, last_mid = '0;

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_dac(string req, int c, logic [15:0] e);
    chk(req, {8'h00, dac[c*DW +: DW]}, {8'h00, e});
  endtask

  function automatic logic [15:0] m_read(logic [6:0] a);
    case (a)
      7'h01: return 16'h0A84;
      7'h03: return m_spi;
      7'h04: return m_gen;
      7'h05: return m_brd;
      7'h09: return m_pwd;
      7'h0A: return m_rng;
      7'h10, 7'h11, 7'h12, 7'h13: return m_buf[int'(a) - 16];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic m_apply(logic [23:0] f);
    logic [6:0]  a = f[22:16];
    logic [15:0] d = f[15:0];
    if (f[23]) m_pend = {8'h00, m_read(a)};
    else begin
      m_pend = '0;
      case (a)
        7'h03: m_spi = d;
        7'h04: m_gen = d;
        7'h05: m_brd = d;
        7'h09: m_pwd = d;
        7'h0A: m_rng = d;
        7'h0E: if (d[0]) for (int c = 0; c < NCH; c++) m_act[c] = m_buf[c];
        7'h10, 7'h11, 7'h12, 7'h13: begin
          m_buf[int'(a) - 16] = d;
          if (!m_gen[int'(a) - 16]) m_act[int'(a) - 16] = d;
        end
        default: ;
      endcase
    end
  endtask

  task automatic spi(logic [23:0] tx, int nbits);
    logic [23:0] exp = m_pend;
    logic [23:0] rx = '0, mid = '0;
    settle = 1'b1;
    wclk(1);
    sclk = mode2;
    wclk(Q);
    cs_n = 1'b0;
    wclk(H);
    for (int i = 0; i < nbits; i++) begin
      sdin = tx[23-i];
      wclk(Q);
      if (!mode2) begin
        sclk = 1'b1; wclk(H);
        rx[23-i] = sdo;
        sclk = 1'b0; wclk(Q);
        mid[23-i] = sdo;
      end else begin
        rx[23-i] = sdo;
        sclk = 1'b0; wclk(Q);
        mid[23-i] = sdo;
        wclk(H - Q);
        sclk = 1'b1; wclk(Q);
      end
    end
    wclk(H);
    cs_n = 1'b1;
    sdin = 1'b0;
    if (nbits == 24) m_apply(tx);
    wclk(2*H);
    settle = 1'b0;
    if (nbits == 24) chk("R5 returned frame", rx, exp);
    last_rx  = rx;
    last_mid = mid;
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    spi({1'b0, a, d}, 24);
  endtask

  task automatic rd(logic [6:0] a, output logic [15:0] v);
    spi({1'b1, a, 16'h0000}, 24);
    spi(24'h000000, 24);
    v = last_rx[15:0];
  endtask

  task automatic ldac_pulse();
    settle = 1'b1;
    wclk(1);
    ldac_n = 1'b0;
    for (int c = 0; c < NCH; c++) m_act[c] = m_buf[c];
    wclk(H);
    ldac_n = 1'b1;
    wclk(H);
    settle = 1'b0;
  endtask

  // per-clock comparison of output codes against the model (R8, R9, R11)
  always @(negedge clk) begin
    if (rst_n && !settle && !done) begin
      for (int c = 0; c < NCH; c++) begin
        logic [15:0] e = m_spi[5] ? 16'h0000 : m_act[c];
        n_cmp++;
        if (dac[c*DW +: DW] !== e) begin
          n_bad++;
          $display("FAIL R8/R9/R11 ch%0d code: actual %h expected %h", c, dac[c*DW +: DW], e);
        end
      end
    end
  end

  initial begin
    logic [15:0] v;
    for (int c = 0; c < NCH; c++) begin m_buf[c] = '0; m_act[c] = '0; end
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    settle = 1'b0;

    for (int c = 0; c < NCH; c++) chk_dac("R6 reset code", c, 16'h0000);
    chk("R5 sdo idle", {23'h0, sdo}, 24'h0);
    rd(7'h01, v); chk("R6 id", {8'h0, v}, 24'h000A84);
    rd(7'h03, v); chk("R6 spicfg", {8'h0, v}, 24'h000AA4);
    rd(7'h04, v); chk("R6 gencfg", {8'h0, v}, 24'h0);
    rd(7'h10, v); chk("R6 data A", {8'h0, v}, 24'h0);

    wr(7'h03, 16'h0A84);
    wr(7'h10, 16'h1234);
    chk_dac("R1 R8 immediate write A", 0, 16'h1234);
    rd(7'h10, v); chk("R12 buffer A", {8'h0, v}, 24'h001234);

    wr(7'h01, 16'hFFFF);
    rd(7'h01, v); chk("R7 id read-only", {8'h0, v}, 24'h000A84);
    wr(7'h07, 16'h5A5A);
    rd(7'h07, v); chk("R7 unmapped", {8'h0, v}, 24'h0);

    spi({1'b0, 7'h11, 16'hAAAA}, 10);
    chk_dac("R2 partial frame", 1, 16'h0000);
    rd(7'h11, v); chk("R2 buffer untouched", {8'h0, v}, 24'h0);

    wr(7'h04, 16'h000E);
    wr(7'h11, 16'h1111);
    wr(7'h12, 16'h2222);
    chk_dac("R9 deferred B held", 1, 16'h0000);
    chk_dac("R9 deferred C held", 2, 16'h0000);
    rd(7'h11, v); chk("R12 buffer B", {8'h0, v}, 24'h001111);
    ldac_pulse();
    chk_dac("R9 load pin B", 1, 16'h1111);
    chk_dac("R9 load pin C", 2, 16'h2222);

    wr(7'h13, 16'h3333);
    chk_dac("R10 D before trigger", 3, 16'h0000);
    wr(7'h0E, 16'h0001);
    chk_dac("R10 soft trigger D", 3, 16'h3333);
    rd(7'h0E, v); chk("R10 trigger reads zero", {8'h0, v}, 24'h0);

    wr(7'h03, 16'h0AA4);
    chk_dac("R11 power-down A", 0, 16'h0000);
    rd(7'h10, v); chk("R11 buffer kept", {8'h0, v}, 24'h001234);
    wr(7'h03, 16'h0A84);
    chk_dac("R11 restored A", 0, 16'h1234);

    mode2 = 1'b1;
    wr(7'h10, 16'hBEEF);
    chk_dac("R3 mode 2 write", 0, 16'hBEEF);
    rd(7'h10, v); chk("R3 mode 2 read", {8'h0, v}, 24'h00BEEF);
    mode2 = 1'b0;

    rd(7'h01, v);
    chk("R4 rising launch mid-bit", last_mid, 24'h000A84);
    wr(7'h03, 16'h0A86);
    rd(7'h01, v);
    chk("R4 falling launch mid-bit", last_mid, 24'h001508);
    chk("R4 falling launch word", {8'h0, v}, 24'h000A84);
    mode2 = 1'b1;
    rd(7'h12, v); chk("R4 R3 falling launch mode 2", {8'h0, v}, 24'h002222);
    mode2 = 1'b0;
    chk("R5 sdo idle end", {23'h0, sdo}, 24'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule